// File: doc/BRIEF.md
# NMI Gating Controller with Management-Mode Tracking

This controller sits beside a processor core and decides in which cycle a non-maskable interrupt may reach it. It follows the blocking state of that interrupt. It holds at most one request that cannot be served yet. It raises a single-cycle `nmi_deliver` pulse at an instruction boundary once a held request is free to go.

The core can drop into a system management mode and later resume the code it interrupted. Entering that mode blocks the interrupt at once. A request that arrives while the mode is active is held and served after resume. The only blocking carried back on resume is the mask the core had set on purpose (`nmi_mask`). Blocking that comes from an interrupt handler still running at entry is lost. As a result, a second NMI can nest inside a handler that has not finished.

An interrupt-return strobe lifts the blocking, including inside the mode. After that, interrupts inside the mode are served as they are outside it.

Top module: `nmi_gate_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears the pending flag, the in-mode flag and all internal blocking. After reset, `nmi_blocked` equals `nmi_mask`.
- R2: An `smm_enter` strobe sets `in_smm` and `nmi_blocked` on the next cycle, whatever the state before it.
- R3: An `nmi_req` pulse sets `nmi_pending` on the next cycle. At most one request is held, and a request that arrives while one is already pending adds no second delivery.
- R4: `nmi_deliver` is high, for exactly one cycle, only when all of these hold in that cycle: `insn_bnd` and `nmi_ack` are high, a request is pending, `nmi_blocked` is low, and `smm_enter` is low. On the next cycle the pending flag is clear (unless a new request arrived) and `nmi_blocked` is high.
- R5: An `iret_strobe` clears the internal blocking, both inside and outside the mode. A pending request inside the mode is then delivered at the next boundary.
- R6: If `nmi_mask` was low at entry, `nmi_blocked` is low on the cycle after `smm_resume`. A request held during the mode is then delivered at the first boundary where `nmi_ack` is high.
- R7: If `nmi_mask` was high at entry, `nmi_blocked` stays high after `smm_resume`, even if the mask has been lowered in the meantime. It stays high until an `iret_strobe`.
- R8: Blocking from a handler that was running at entry is not restored on resume. A request held during the mode is delivered after resume, nested in that handler.
- R9: When `smm_enter` comes in the same cycle as an instruction boundary with a deliverable request, or together with a new request, nothing is delivered and the request stays pending.
- R10: Inside the mode the `nmi_mask` input is ignored. After an `iret_strobe` in the mode, `nmi_blocked` is low even while `nmi_mask` is high.
- R11: At a boundary where `nmi_ack` is low, nothing is delivered and the pending request is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_req | input | 1 | Incoming NMI request pulse |
| smm_enter | input | 1 | Entry into management mode |
| smm_resume | input | 1 | Resume from management mode |
| iret_strobe | input | 1 | Interrupt-return executed |
| insn_bnd | input | 1 | Instruction boundary reached |
| nmi_ack | input | 1 | Core can take an NMI at this boundary |
| nmi_mask | input | 1 | Explicit NMI mask held by the core outside the mode |
| nmi_deliver | output | 1 | One-cycle delivery pulse |
| nmi_blocked | output | 1 | NMI delivery currently blocked |
| nmi_pending | output | 1 | A request is held |
| in_smm | output | 1 | Management mode active |

## Verification
The bench drives an entry while a handler is still running and then checks that the held request comes out after resume. A design that restored handler blocking would stay silent there.

It sends two requests during the mode and expects only one delivery. A design that counted requests would fire twice.

It places an entry in the same cycle as a deliverable boundary. A design that let delivery win would pulse there.

It raises the mask before entry and lowers it inside the mode. A design that restored the live mask, instead of the captured one, would unblock at resume. Holding the mask high inside the mode after a return shows whether the design wrongly honours the mask while in the mode.

// File: rtl/nmi_gate_pkg.sv
package nmi_gate_pkg;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_ENTER,
        EV_RESUME,
        EV_IRET
    } mode_event_t;

    typedef struct packed {
        logic in_smm;
        logic blk;
        logic saved_mask;
    } blk_state_t;

    typedef struct packed {
        logic pending;
    } pend_state_t;

endpackage

// File: rtl/nmi_block_track.sv
module nmi_block_track
    import nmi_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic smm_enter,
    input  logic smm_resume,
    input  logic iret_strobe,
    input  logic deliver,
    input  logic nmi_mask,
    output logic in_smm,
    output logic blocked
);

    blk_state_t  st_d, st_q;
    mode_event_t ev;

    // entry outranks resume, resume outranks return
    always_comb begin
        if (smm_enter)
            ev = EV_ENTER;
        else if (smm_resume && st_q.in_smm)
            ev = EV_RESUME;
        else if (iret_strobe)
            ev = EV_IRET;
        else
            ev = EV_NONE;
    end

    always_comb begin
        st_d = st_q;
        unique case (ev)
            EV_ENTER: begin
                st_d.in_smm     = 1'b1;
                st_d.blk        = 1'b1;
                st_d.saved_mask = st_q.in_smm ? st_q.saved_mask : nmi_mask;
            end
            EV_RESUME: begin
                st_d.in_smm = 1'b0;
                st_d.blk    = st_q.saved_mask;
            end
            EV_IRET:  st_d.blk = 1'b0;
            default:  st_d = st_q;
        endcase
        // a delivered NMI starts its handler: blocked until a return
        if (deliver)
            st_d.blk = 1'b1;
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign in_smm  = st_q.in_smm;
    assign blocked = st_q.blk | (~st_q.in_smm & nmi_mask);

endmodule

// File: rtl/nmi_pend_latch.sv
module nmi_pend_latch
    import nmi_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nmi_req,
    input  logic deliver,
    output logic pending
);

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (deliver)
            st_d.pending = 1'b0;
        // a single slot: a request on a full slot merges away
        if (nmi_req)
            st_d.pending = 1'b1;
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pending = st_q.pending;

endmodule

// File: rtl/nmi_deliver_gate.sv
module nmi_deliver_gate (
    input  logic insn_bnd,
    input  logic nmi_ack,
    input  logic pending,
    input  logic blocked,
    input  logic smm_enter,
    output logic deliver
);

    logic window_open;

    always_comb begin
        window_open = insn_bnd & nmi_ack & ~smm_enter;
        deliver     = window_open & pending & ~blocked;
    end

endmodule

// File: rtl/nmi_gate_ctrl.sv
module nmi_gate_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic nmi_req,
    input  logic smm_enter,
    input  logic smm_resume,
    input  logic iret_strobe,
    input  logic insn_bnd,
    input  logic nmi_ack,
    input  logic nmi_mask,
    output logic nmi_deliver,
    output logic nmi_blocked,
    output logic nmi_pending,
    output logic in_smm
);

    logic deliver_w;
    logic blocked_w;
    logic pending_w;
    logic in_smm_w;

    nmi_block_track u_track (
        .clk         (clk),
        .rst         (rst),
        .smm_enter   (smm_enter),
        .smm_resume  (smm_resume),
        .iret_strobe (iret_strobe),
        .deliver     (deliver_w),
        .nmi_mask    (nmi_mask),
        .in_smm      (in_smm_w),
        .blocked     (blocked_w)
    );

    nmi_pend_latch u_pend (
        .clk     (clk),
        .rst     (rst),
        .nmi_req (nmi_req),
        .deliver (deliver_w),
        .pending (pending_w)
    );

    nmi_deliver_gate u_gate (
        .insn_bnd  (insn_bnd),
        .nmi_ack   (nmi_ack),
        .pending   (pending_w),
        .blocked   (blocked_w),
        .smm_enter (smm_enter),
        .deliver   (deliver_w)
    );

    assign nmi_deliver = deliver_w;
    assign nmi_blocked = blocked_w;
    assign nmi_pending = pending_w;
    assign in_smm      = in_smm_w;

endmodule

// File: rtl/nmi_gate_checker.sv
module nmi_gate_checker (
    input logic clk,
    input logic rst,
    input logic nmi_req,
    input logic smm_enter,
    input logic smm_resume,
    input logic iret_strobe,
    input logic insn_bnd,
    input logic nmi_ack,
    input logic nmi_deliver,
    input logic nmi_blocked,
    input logic nmi_pending,
    input logic in_smm
);

    assert_enter_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        smm_enter |=> (in_smm && nmi_blocked));

    assert_pending_held_R3: assert property (@(posedge clk) disable iff (rst)
        (nmi_pending && !nmi_deliver) |=> nmi_pending);

    assert_request_latched_R3: assert property (@(posedge clk) disable iff (rst)
        nmi_req |=> nmi_pending);

    assert_deliver_cond_R4: assert property (@(posedge clk) disable iff (rst)
        nmi_deliver |-> (insn_bnd && nmi_ack && nmi_pending && !nmi_blocked));

    assert_deliver_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        nmi_deliver |=> (nmi_blocked && !nmi_deliver));

    assert_iret_unblocks_R5: assert property (@(posedge clk) disable iff (rst)
        (in_smm && iret_strobe && !smm_enter && !smm_resume && !nmi_deliver)
        |=> !nmi_blocked);

    assert_resume_leaves_R6: assert property (@(posedge clk) disable iff (rst)
        (in_smm && smm_resume && !smm_enter) |=> !in_smm);

    assert_entry_wins_R9: assert property (@(posedge clk) disable iff (rst)
        smm_enter |-> !nmi_deliver);

endmodule

bind nmi_gate_ctrl nmi_gate_checker u_checker (
    .clk         (clk),
    .rst         (rst),
    .nmi_req     (nmi_req),
    .smm_enter   (smm_enter),
    .smm_resume  (smm_resume),
    .iret_strobe (iret_strobe),
    .insn_bnd    (insn_bnd),
    .nmi_ack     (nmi_ack),
    .nmi_deliver (nmi_deliver),
    .nmi_blocked (nmi_blocked),
    .nmi_pending (nmi_pending),
    .in_smm      (in_smm)
);

// File: tb/nmi_gate_ctrl_test.sv
module nmi_gate_ctrl_test;

    logic clk = 1'b0;
    logic rst;
    logic nmi_req, smm_enter, smm_resume, iret_strobe, insn_bnd, nmi_ack, nmi_mask;
    logic nmi_deliver, nmi_blocked, nmi_pending, in_smm;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    nmi_gate_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .nmi_req     (nmi_req),
        .smm_enter   (smm_enter),
        .smm_resume  (smm_resume),
        .iret_strobe (iret_strobe),
        .insn_bnd    (insn_bnd),
        .nmi_ack     (nmi_ack),
        .nmi_mask    (nmi_mask),
        .nmi_deliver (nmi_deliver),
        .nmi_blocked (nmi_blocked),
        .nmi_pending (nmi_pending),
        .in_smm      (in_smm)
    );

    // bits: req enter resume iret bnd ack mask | dlv blk pend smm
    localparam int NV = 29;
    localparam logic [10:0] VEC [NV] = '{
        11'b0000000_0000, // 0  idle
        11'b1000000_0010, // 1  request latched
        11'b0000110_1100, // 2  delivered
        11'b1000000_0110, // 3  request during handler
        11'b0000110_0110, // 4  blocked boundary
        11'b0001000_0010, // 5  return unblocks
        11'b0000100_0010, // 6  no ack
        11'b0000110_1100, // 7  delivered, handler runs
        11'b0100000_0101, // 8  entry during handler
        11'b1000000_0111, // 9  request in mode
        11'b1000000_0111, // 10 second request merged
        11'b0010000_0010, // 11 resume forgets handler
        11'b0000110_1100, // 12 nested delivery
        11'b0000110_0100, // 13 no second delivery
        11'b0001000_0000, // 14 return
        11'b1000000_0010, // 15 request
        11'b1100110_0111, // 16 entry beats boundary
        11'b0001000_0011, // 17 return in mode
        11'b0000110_1101, // 18 delivered in mode
        11'b0010000_0000, // 19 resume, mask was low
        11'b0000001_0100, // 20 mask raised
        11'b0100001_0101, // 21 entry with mask
        11'b0001001_0001, // 22 return in mode, mask ignored
        11'b0000000_0001, // 23 mask dropped in mode
        11'b0010000_0100, // 24 resume keeps captured mask
        11'b1000110_0110, // 25 request, still blocked
        11'b0001000_0010, // 26 return
        11'b0000110_1100, // 27 delivered
        11'b0001000_0000  // 28 return
    };

    function automatic string vec_tag(int i);
        case (i)
            0:               return "R1";
            1, 3, 9, 10, 13: return "R3";
            2, 4, 7, 27:     return "R4";
            5, 14, 17, 18:   return "R5";
            6:               return "R11";
            8, 21:           return "R2";
            11, 12:          return "R8";
            15, 16:          return "R9";
            19:              return "R6";
            20, 22, 23:      return "R10";
            default:         return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] v);
        {nmi_req, smm_enter, smm_resume, iret_strobe, insn_bnd, nmi_ack, nmi_mask} = v;
    endtask

    initial begin
        drive('0);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #5;
        check("R1", "pending after reset", nmi_pending, 1'b0);
        check("R1", "in_smm after reset", in_smm, 1'b0);
        check("R1", "blocked after reset", nmi_blocked, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][10:4]);
            #5;
            check(vec_tag(i), $sformatf("deliver vec %0d", i), nmi_deliver, VEC[i][3]);
            @(posedge clk);
            #5;
            check(vec_tag(i), $sformatf("blocked vec %0d", i), nmi_blocked, VEC[i][2]);
            check(vec_tag(i), $sformatf("pending vec %0d", i), nmi_pending, VEC[i][1]);
            check(vec_tag(i), $sformatf("in_smm vec %0d", i), in_smm, VEC[i][0]);
            @(negedge clk);
        end

        // R1: reset dominates active strobes and clears a busy state
        drive(7'b1100000);
        @(posedge clk);
        @(negedge clk);
        drive(7'b1000000);
        rst = 1'b1;
        @(posedge clk);
        #5;
        check("R1", "pending after mid reset", nmi_pending, 1'b0);
        check("R1", "in_smm after mid reset", in_smm, 1'b0);
        check("R1", "blocked after mid reset", nmi_blocked, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        drive(7'b0000001);
        #5;
        check("R1", "blocked follows mask after reset", nmi_blocked, 1'b1);
        @(negedge clk);
        drive('0);

        // R6: held request delivered at first acked boundary after resume
        drive(7'b0100000);
        @(negedge clk);
        drive(7'b1000000);
        @(negedge clk);
        drive(7'b0010110);
        #5;
        check("R6", "no deliver in resume cycle", nmi_deliver, 1'b0);
        @(negedge clk);
        drive(7'b0000110);
        #5;
        check("R6", "deliver at first boundary after resume", nmi_deliver, 1'b1);
        @(negedge clk);
        drive('0);
        #5;
        check("R4", "pulse lasts one cycle", nmi_deliver, 1'b0);
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule